// File: doc/BRIEF.md
# Virtio Interrupt Status and Queue Notify Unit

This block sits in the register window of a paravirtual device. It owns two 32-bit aligned registers. The notify register is write-only in practice: a driver writes a queue index to it, and the block sends a one-cycle doorbell pulse to the back end for that queue. The interrupt-status register reports why the device interrupted. Reading it returns the pending causes and clears them in the same access.

On the back-end side there are two inputs. Queue-completion requests come in per queue. Configuration-change events come in on a single pulse, and each one also advances a wrapping generation counter. A mode input picks how interrupts are signalled. In line mode the block drives one level-sensitive interrupt line, which a status read drops. In message mode the block presents a valid/vector request for each event and holds it until the message path accepts it. Config changes use the config vector and queue completions use that queue's own vector.

A device-reset input returns the whole unit to its idle state. The block does not hold the vector table, does not deliver messages on the bus and does not process queues.

Top module: `virtqIrqNotify`

## Requirements
- R1: A write to byte offset 56 whose full 32-bit data value q is below NUM_QUEUES drives `doorbell[q]` high for exactly the one cycle after the write edge. All other doorbell bits stay low.
- R2: A write to offset 56 with a data value of NUM_QUEUES or more produces no doorbell pulse. A read of offset 56, or of any offset other than 60, returns 0.
- R3: A read of offset 60 returns the status in bits [1:0], with bit 0 = queue completion and bit 1 = configuration change, and zeros above. From the next edge the status is zero. In line mode the same read drops `irqLine`.
- R4: A queue-completion request (any bit of `qIrqReq`) sets status bit 0 in either mode. In line mode it also raises `irqLine` from the next edge.
- R5: Every configuration-change pulse increments `cfgGen` by one, whatever `driverOk` is. The counter wraps from 2^GEN_W-1 to 0.
- R6: A configuration-change pulse sets status bit 1 only while `driverOk` is high. In line mode it then also raises `irqLine`. Without `driverOk` it changes neither.
- R7: In message mode `irqLine` never rises. Each request becomes a `msgValid` with a `msgVector`, and both hold steady until `msgReady`. A config change uses `cfgVector`; queue q uses bits [q*VEC_W +: VEC_W] of `queueVectors`. When several requests are pending, the config change goes first, then queues in ascending index order.
- R8: If a status read and a new status set fall in the same cycle, the read returns the old value, and the new cause stays set afterwards. In line mode the line stays high.
- R9: A `devReset` cycle clears the status, `irqLine`, `cfgGen`, all pending message requests and `msgValid`. It takes priority over any request in the same cycle.
- R10: After `rst_n` the outputs are all zero and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte offset within the window |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, valid in the cycle of regRdEn |
| msgMode | input | 1 | 1 = message signalling, 0 = level line |
| driverOk | input | 1 | Driver-ready status bit |
| devReset | input | 1 | Device reset pulse |
| qIrqReq | input | NUM_QUEUES | Per-queue completion interrupt requests |
| cfgChange | input | 1 | Configuration-change event pulse |
| cfgVector | input | VEC_W | Message vector for config changes |
| queueVectors | input | NUM_QUEUES*VEC_W | Per-queue message vectors, packed |
| msgReady | input | 1 | Message path accepts the presented request |
| msgValid | output | 1 | Message request present |
| msgVector | output | VEC_W | Vector of the presented request |
| irqLine | output | 1 | Level interrupt line (line mode) |
| doorbell | output | NUM_QUEUES | One-cycle per-queue notify pulses |
| cfgGen | output | GEN_W | Configuration generation counter |

## Verification
A status register holding a wrong value is visible at the next read of offset 60. The same fault usually appears even sooner as a wrong level on `irqLine`, one edge after the event. A lost or duplicated pending message shows up as a missing or extra `msgValid` handshake. An arbiter choosing the wrong source shows up as a wrong `msgVector` two edges after the request. A request held over a stall must not change vector while `msgReady` is low. Faults in the doorbell decode show up on the cycle directly after the write, as a pulse on the wrong bit or a pulse where none is allowed.

// File: rtl/virtqIrqPkg.sv
package virtqIrqPkg;

  localparam int STAT_W     = 2;
  localparam int STAT_QUEUE = 0;
  localparam int STAT_CFG   = 1;

  // Strobes from the decode/control half to the datapath half
  typedef struct packed {
    logic devRst;     // device reset, dominates all
    logic isrRead;    // read of the status register this cycle
    logic notifyHit;  // notify write with an in-range index
    logic setQ;       // set queue-completion status bit
    logic setCfg;     // set config-change status bit
    logic bumpGen;    // advance generation counter
    logic raiseLine;  // assert level line
    logic dropLine;   // deassert level line
    logic pendCfg;    // queue a config-change message
    logic pendQ;      // queue per-queue messages
  } irqStrobe_t;

endpackage

// File: rtl/virtqIrqCtrl.sv
module virtqIrqCtrl
  import virtqIrqPkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NOTIFY_OFS = 56,
  parameter int ISR_OFS    = 60
) (
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  msgMode,
  input  logic                  driverOk,
  input  logic                  devReset,
  input  logic [NUM_QUEUES-1:0] qIrqReq,
  input  logic                  cfgChange,
  output irqStrobe_t            strb
);

  logic atNotify, atIsr, idxOk, anyQ, cfgLive;

  always_comb begin
    atNotify = (regAddr == ADDR_W'(NOTIFY_OFS));
    atIsr    = (regAddr == ADDR_W'(ISR_OFS));
    idxOk    = (regWrData < DATA_W'(NUM_QUEUES));
    anyQ     = |qIrqReq;
    cfgLive  = cfgChange && driverOk;

    strb.devRst    = devReset;
    strb.isrRead   = regRdEn && atIsr;
    strb.notifyHit = regWrEn && atNotify && idxOk;
    strb.setQ      = anyQ;
    strb.setCfg    = cfgLive;
    strb.bumpGen   = cfgChange;
    strb.raiseLine = !msgMode && (anyQ || cfgLive);
    strb.dropLine  = !msgMode && regRdEn && atIsr;
    strb.pendCfg   = msgMode && cfgLive;
    strb.pendQ     = msgMode;
  end

endmodule

// File: rtl/virtqIrqDatapath.sv
module virtqIrqDatapath
  import virtqIrqPkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int VEC_W      = 16,
  parameter int GEN_W      = 8,
  parameter int DATA_W     = 32,
  parameter int QIDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  irqStrobe_t                  strb,
  input  logic [QIDX_W-1:0]           notifyIdx,
  input  logic [NUM_QUEUES-1:0]       qIrqReq,
  input  logic [VEC_W-1:0]            cfgVector,
  input  logic [NUM_QUEUES*VEC_W-1:0] queueVectors,
  input  logic                        msgReady,
  output logic                        msgValid,
  output logic [VEC_W-1:0]            msgVector,
  output logic                        irqLine,
  output logic [NUM_QUEUES-1:0]       doorbell,
  output logic [GEN_W-1:0]            cfgGen,
  output logic [DATA_W-1:0]           rdData
);

  // Source 0 is the config change, source q+1 is queue q
  localparam int SRC    = NUM_QUEUES + 1;
  localparam int SRC_W  = $clog2(SRC);
  localparam int SRC_P2 = 1 << SRC_W;

  logic [STAT_W-1:0] status, statNext;
  logic              lineNext;

  // ---------------- status and level line ----------------
  always_comb begin
    statNext = strb.isrRead ? '0 : status;
    statNext[STAT_QUEUE] = statNext[STAT_QUEUE] | strb.setQ;
    statNext[STAT_CFG]   = statNext[STAT_CFG] | strb.setCfg;
    lineNext = (irqLine && !strb.dropLine) || strb.raiseLine;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.devRst) begin
      status  <= '0;
      irqLine <= 1'b0;
      cfgGen  <= '0;
    end else begin
      status  <= statNext;
      irqLine <= lineNext;
      if (strb.bumpGen) cfgGen <= cfgGen + GEN_W'(1);
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.isrRead) rdData[STAT_W-1:0] = status;
  end

  // ---------------- doorbell pulses ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) doorbell <= '0;
    else if (strb.notifyHit) doorbell <= NUM_QUEUES'(1) << notifyIdx;
    else doorbell <= '0;
  end

  // ---------------- message requests ----------------
  logic [VEC_W-1:0] srcVec [SRC_P2];
  assign srcVec[0] = cfgVector;
  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_qvec
    assign srcVec[q+1] = queueVectors[q*VEC_W +: VEC_W];
  end
  for (genvar e = SRC; e < SRC_P2; e++) begin : g_pad
    assign srcVec[e] = '0;
  end

  logic [SRC-1:0]   pend, pendSet, grantMask;
  logic [SRC_W-1:0] pickIdx;
  logic             pickAny, grantNow, busy;
  logic [VEC_W-1:0] vecHeld;

  always_comb begin
    pendSet = {qIrqReq & {NUM_QUEUES{strb.pendQ}}, strb.pendCfg};
    pickAny = |pend;
    pickIdx = '0;
    for (int s = SRC - 1; s >= 0; s--) begin
      if (pend[s]) pickIdx = SRC_W'(s);
    end
    grantNow  = !busy && pickAny;
    grantMask = grantNow ? (SRC'(1) << pickIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.devRst) begin
      pend    <= '0;
      busy    <= 1'b0;
      vecHeld <= '0;
    end else begin
      pend <= (pend & ~grantMask) | pendSet;
      if (busy && msgReady) begin
        busy <= 1'b0;
      end else if (grantNow) begin
        busy    <= 1'b1;
        vecHeld <= srcVec[pickIdx];
      end
    end
  end

  assign msgValid  = busy;
  assign msgVector = vecHeld;

endmodule

// File: rtl/virtqIrqNotify.sv
module virtqIrqNotify
  import virtqIrqPkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int VEC_W      = 16,
  parameter int GEN_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NOTIFY_OFS = 56,
  parameter int ISR_OFS    = 60
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        regWrEn,
  input  logic                        regRdEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  output logic [DATA_W-1:0]           regRdData,
  input  logic                        msgMode,
  input  logic                        driverOk,
  input  logic                        devReset,
  input  logic [NUM_QUEUES-1:0]       qIrqReq,
  input  logic                        cfgChange,
  input  logic [VEC_W-1:0]            cfgVector,
  input  logic [NUM_QUEUES*VEC_W-1:0] queueVectors,
  input  logic                        msgReady,
  output logic                        msgValid,
  output logic [VEC_W-1:0]            msgVector,
  output logic                        irqLine,
  output logic [NUM_QUEUES-1:0]       doorbell,
  output logic [GEN_W-1:0]            cfgGen
);

  localparam int QIDX_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;

  irqStrobe_t strb;

  virtqIrqCtrl #(
    .NUM_QUEUES(NUM_QUEUES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .NOTIFY_OFS(NOTIFY_OFS), .ISR_OFS(ISR_OFS)
  ) u_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .msgMode(msgMode), .driverOk(driverOk),
    .devReset(devReset), .qIrqReq(qIrqReq), .cfgChange(cfgChange),
    .strb(strb)
  );

  virtqIrqDatapath #(
    .NUM_QUEUES(NUM_QUEUES), .VEC_W(VEC_W), .GEN_W(GEN_W),
    .DATA_W(DATA_W), .QIDX_W(QIDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .notifyIdx(regWrData[QIDX_W-1:0]), .qIrqReq(qIrqReq),
    .cfgVector(cfgVector), .queueVectors(queueVectors),
    .msgReady(msgReady), .msgValid(msgValid), .msgVector(msgVector),
    .irqLine(irqLine), .doorbell(doorbell), .cfgGen(cfgGen),
    .rdData(regRdData)
  );

endmodule

// File: rtl/virtqIrqNotifyChk.sv
module virtqIrqNotifyChk #(
  parameter int NUM_QUEUES = 4,
  parameter int VEC_W      = 16,
  parameter int GEN_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int NOTIFY_OFS = 56,
  parameter int ISR_OFS    = 60
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  regWrEn,
  input logic                  regRdEn,
  input logic [ADDR_W-1:0]     regAddr,
  input logic                  msgMode,
  input logic                  driverOk,
  input logic                  devReset,
  input logic [NUM_QUEUES-1:0] qIrqReq,
  input logic                  cfgChange,
  input logic                  msgReady,
  input logic                  msgValid,
  input logic [VEC_W-1:0]      msgVector,
  input logic                  irqLine,
  input logic [NUM_QUEUES-1:0] doorbell,
  input logic [GEN_W-1:0]      cfgGen
);

  // R1
  doorbell_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(doorbell));

  // R1
  doorbell_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell != '0) |-> $past(regWrEn && regAddr == ADDR_W'(NOTIFY_OFS)));

  // R3
  line_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(regRdEn && regAddr == ADDR_W'(ISR_OFS) && !msgMode && qIrqReq == '0
          && !(cfgChange && driverOk)) |-> !irqLine);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past((qIrqReq != '0) && !msgMode && !devReset) |-> irqLine);

  // R7
  no_line_rise_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqLine) |-> $past(!msgMode));

  // R7
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && !msgReady && !devReset) |=> (msgValid && $stable(msgVector)));

  // R9
  dev_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(devReset) |-> (!irqLine && !msgValid && cfgGen == '0));

endmodule

bind virtqIrqNotify virtqIrqNotifyChk #(
  .NUM_QUEUES(NUM_QUEUES), .VEC_W(VEC_W), .GEN_W(GEN_W),
  .ADDR_W(ADDR_W), .NOTIFY_OFS(NOTIFY_OFS), .ISR_OFS(ISR_OFS)
) chk (.*);

// File: tb/virtqIrqNotify_test.sv
`timescale 1ns/1ps
module virtqIrqNotify_test;

  localparam int NQ = 4;
  localparam int VW = 16;
  localparam int GW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic msgMode = 0, driverOk = 0, devReset = 0, cfgChange = 0, msgReady = 0;
  logic [NQ-1:0] qIrqReq = '0;
  logic [VW-1:0] cfgVector = 16'h0100;
  logic [NQ*VW-1:0] queueVectors;
  logic msgValid, irqLine;
  logic [VW-1:0] msgVector;
  logic [NQ-1:0] doorbell;
  logic [GW-1:0] cfgGen;

  int nChecks = 0;
  int nFails = 0;
  int genExp = 0;

  always #2 clk = ~clk;

  initial begin
    for (int q = 0; q < NQ; q++) queueVectors[q*VW +: VW] = VW'(16'h0010 + q);
  end

  virtqIrqNotify uut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .msgMode(msgMode), .driverOk(driverOk), .devReset(devReset),
    .qIrqReq(qIrqReq), .cfgChange(cfgChange), .cfgVector(cfgVector),
    .queueVectors(queueVectors), .msgReady(msgReady), .msgValid(msgValid),
    .msgVector(msgVector), .irqLine(irqLine), .doorbell(doorbell),
    .cfgGen(cfgGen)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // read offset, check returned data in the access cycle
  task automatic readReg(input logic [7:0] ofs, input logic [31:0] exp, input string req);
    regRdEn = 1; regAddr = ofs;
    #1 chk(req, regRdData, exp);
    step();
    regRdEn = 0;
  endtask

  task automatic pulseCfg();
    cfgChange = 1; step(); cfgChange = 0;
    genExp = (genExp + 1) % (1 << GW);
  endtask

  task automatic testReset();
    chk("R10 irqLine", 32'(irqLine), 0);
    chk("R10 msgValid", 32'(msgValid), 0);
    chk("R10 doorbell", 32'(doorbell), 0);
    chk("R10 cfgGen", 32'(cfgGen), 0);
    readReg(8'd60, 0, "R10 status");
  endtask

  task automatic testNotify();
    regWrEn = 1; regAddr = 8'd56; regWrData = 32'd2; step(); regWrEn = 0;
    chk("R1 doorbell q2", 32'(doorbell), 32'h4);
    step();
    chk("R1 pulse one cycle", 32'(doorbell), 0);
    regWrEn = 1; regWrData = 32'd0; step(); regWrEn = 0;
    chk("R1 doorbell q0", 32'(doorbell), 32'h1);
    regWrEn = 1; regWrData = 32'd4; step(); regWrEn = 0;
    chk("R2 index at count ignored", 32'(doorbell), 0);
    regWrEn = 1; regWrData = 32'h0000_0101; step(); regWrEn = 0;
    chk("R2 wide index ignored", 32'(doorbell), 0);
    step();
    chk("R2 no late pulse", 32'(doorbell), 0);
    readReg(8'd56, 0, "R2 notify reads zero");
  endtask

  task automatic testLineQueue();
    qIrqReq = 4'b0100; step(); qIrqReq = '0;
    chk("R4 line raised", 32'(irqLine), 1);
    readReg(8'd60, 32'h1, "R3 status queue bit");
    chk("R3 line dropped", 32'(irqLine), 0);
    readReg(8'd60, 0, "R3 status cleared");
    readReg(8'd44, 0, "R2 other offset zero");
  endtask

  task automatic testCfgGate();
    driverOk = 0;
    pulseCfg();
    chk("R5 gen without driverOk", 32'(cfgGen), 32'(genExp));
    chk("R6 no line without driverOk", 32'(irqLine), 0);
    readReg(8'd60, 0, "R6 no status without driverOk");
    driverOk = 1;
    pulseCfg();
    chk("R5 gen with driverOk", 32'(cfgGen), 32'(genExp));
    chk("R6 line with driverOk", 32'(irqLine), 1);
    readReg(8'd60, 32'h2, "R6 status cfg bit");
    chk("R3 line dropped after cfg", 32'(irqLine), 0);
  endtask

  task automatic testSetWins();
    cfgChange = 1; step(); cfgChange = 0;
    genExp = (genExp + 1) % (1 << GW);
    regRdEn = 1; regAddr = 8'd60; qIrqReq = 4'b0001;
    #1 chk("R8 read returns old", regRdData, 32'h2);
    step();
    regRdEn = 0; qIrqReq = '0;
    chk("R8 line kept", 32'(irqLine), 1);
    readReg(8'd60, 32'h1, "R8 new cause kept");
  endtask

  task automatic testMessage();
    msgMode = 1; driverOk = 1; msgReady = 0;
    qIrqReq = 4'b1010; cfgChange = 1; step(); qIrqReq = '0; cfgChange = 0;
    genExp = (genExp + 1) % (1 << GW);
    chk("R7 line low in msg mode", 32'(irqLine), 0);
    step();
    chk("R7 cfg valid first", 32'(msgValid), 1);
    chk("R7 cfg vector", 32'(msgVector), 32'h0100);
    step(); step();
    chk("R7 hold valid", 32'(msgValid), 1);
    chk("R7 hold vector", 32'(msgVector), 32'h0100);
    readReg(8'd60, 32'h3, "R4 status both bits msg mode");
    msgReady = 1; step(); msgReady = 0;
    chk("R7 accepted", 32'(msgValid), 0);
    step();
    chk("R7 q1 valid", 32'(msgValid), 1);
    chk("R7 q1 vector", 32'(msgVector), 32'h0011);
    msgReady = 1; step(); msgReady = 0;
    step();
    chk("R7 q3 vector", 32'(msgVector), 32'h0013);
    msgReady = 1; step(); msgReady = 0;
    step();
    chk("R7 drained", 32'(msgValid), 0);
    chk("R7 line never raised", 32'(irqLine), 0);
    readReg(8'd60, 0, "R3 msg status cleared");
  endtask

  task automatic testGenWrap();
    msgMode = 0; driverOk = 0;
    for (int i = 0; i < (1 << GW); i++) pulseCfg();
    chk("R5 gen wrap", 32'(cfgGen), 32'(genExp));
  endtask

  task automatic testDevReset();
    driverOk = 1; msgMode = 0;
    qIrqReq = 4'b0001; cfgChange = 1; step(); qIrqReq = '0; cfgChange = 0;
    chk("R9 setup line", 32'(irqLine), 1);
    msgMode = 1; qIrqReq = 4'b0010; step(); qIrqReq = '0;
    step();
    chk("R9 setup msg", 32'(msgValid), 1);
    devReset = 1; qIrqReq = 4'b0001; cfgChange = 1; step();
    devReset = 0; qIrqReq = '0; cfgChange = 0;
    genExp = 0;
    chk("R9 line cleared", 32'(irqLine), 0);
    chk("R9 msg cleared", 32'(msgValid), 0);
    chk("R9 gen cleared", 32'(cfgGen), 0);
    step();
    chk("R9 no pending left", 32'(msgValid), 0);
    readReg(8'd60, 0, "R9 status cleared");
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    testReset();
    testNotify();
    testLineQueue();
    testCfgGate();
    testSetWins();
    readReg(8'd60, 0, "R3 cleared before msg test");
    testMessage();
    testGenWrap();
    testDevReset();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule